// File: doc/BRIEF.md
# Cartridge ROM Bank Switcher

This block sits on a cartridge and selects which 16 KiB page of a large ROM appears in the upper half of the CPU's ROM area. It watches CPU writes and sees only the top three address lines and the low five data lines. Writes to two of the ROM address regions load bank registers. The lower half of the ROM area always shows page 0. The upper half shows the page formed by a 2-bit upper register above a 5-bit lower register.

The block does not know how large the attached ROM is. It always drives all bank lines. A smaller ROM leaves the top lines unconnected, so a bank number beyond its size wraps inside the ROM itself. A lower register value of zero is presented as one. The zero test looks only at the five latched bits, so a number that wraps to zero in a small ROM is not promoted.

Top module: `rom_bank_switch`

## Requirements
- R1: After reset the lower register holds 1 and the upper register holds 0, so a read in the switchable window (address lines 15..13 = 010 or 011) gives bank 1.
- R2: A write strobe with address lines 15..13 = 001 (0x2000–0x3FFF) loads all five data bits into the lower register. The new value shows on bank bits 4..0 from the next clock edge.
- R3: When the lower register holds 0, bank bits 4..0 show 1 instead. A byte of 32 puts zeros on data lines 4..0, so it selects bank 1.
- R4: A nonzero lower value passes to the bank lines unchanged, with no adjustment for ROM size. A value of 16 seen through only four bank lines (2 Mbit ROM) selects page 0, and so does 8 seen through three lines (1 Mbit ROM).
- R5: A write strobe with address lines 15..13 = 010 (0x4000–0x5FFF) loads data bits 1..0 into the upper register. This register drives bank bits 6..5 in the window.
- R6: A read with address line 14 low (0x0000–0x3FFF) gives bank 0 whatever the registers hold.
- R7: Writes with address lines 15..13 equal to 000, 011 or 1xx change neither register.
- R8: With the write strobe low, the registers do not change whatever the address and data are.
- R9: The zero-to-one promotion uses the lower five bits only. With the upper register at 3 and the lower register at 0, the window bank is 0x61.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, sampled at the rising edge |
| addr_hi | input | 3 | CPU address lines 15..13 |
| data_lo | input | 5 | CPU data lines 4..0 |
| rom_bank | output | 7 | ROM bank address lines for the current access |

## Verification
The hardest case to reach is a value that wraps to page 0 inside a small ROM and is still not promoted. It shows up only when the full bank output is cut down to the lines that a 1 Mbit or 2 Mbit ROM would actually connect. The bench writes 16 and 8, then checks the full bank value and also the truncated views. It contrasts these with a write whose five data bits are all zero. A second hard case has a nonzero upper register over a zero lower register. This shows that promotion ignores the upper bits.

// File: rtl/rom_bank_switch.sv
module rom_bank_switch #(
  parameter int LO_W = 5,
  parameter int HI_W = 2,
  parameter logic [2:0] LO_SEL = 3'b001,
  parameter logic [2:0] HI_SEL = 3'b010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           addr_hi,
  input  logic [LO_W-1:0]      data_lo,
  output logic [LO_W+HI_W-1:0] rom_bank
);
  localparam int BANK_W = LO_W + HI_W;
  localparam logic [LO_W-1:0] LO_ONE = LO_W'(1);

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= LO_ONE;
      hi_q <= '0;
    end else if (wr_en) begin
      if (addr_hi == LO_SEL) lo_q <= data_lo;
      if (addr_hi == HI_SEL) hi_q <= data_lo[HI_W-1:0];
    end
  end

  assign lo_eff   = (lo_q == '0) ? LO_ONE : lo_q;
  assign rom_bank = addr_hi[1] ? {hi_q, lo_eff} : BANK_W'(0);
endmodule

module rom_bank_switch_chk #(
  parameter int LO_W = 5,
  parameter int HI_W = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [2:0]           addr_hi,
  input logic [LO_W-1:0]      data_lo,
  input logic [LO_W+HI_W-1:0] rom_bank
);
  assert_window_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hi[1] |-> rom_bank[LO_W-1:0] != '0);

  assert_fixed_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hi[1] |-> rom_bank == '0);

  assert_low_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_hi == 3'b001 && data_lo != '0) |=>
      (!addr_hi[1] || rom_bank[LO_W-1:0] == $past(data_lo)));

  assert_high_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_hi == 3'b010) |=>
      (!addr_hi[1] || rom_bank[LO_W+HI_W-1:LO_W] == $past(data_lo[HI_W-1:0])));

  // R8 also covered: no strobe means no change
  assert_no_stray_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hi[1] && $past(addr_hi[1]) && $past(rst_n) &&
     !($past(wr_en) && ($past(addr_hi) == 3'b001 || $past(addr_hi) == 3'b010)))
      |-> $stable(rom_bank));
endmodule

bind rom_bank_switch rom_bank_switch_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_hi(addr_hi),
  .data_lo(data_lo), .rom_bank(rom_bank));

// File: tb/rom_bank_switch_tb.sv
module rom_bank_switch_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [2:0] addr_hi = 3'b000;
  logic [4:0] data_lo = '0;
  logic [6:0] rom_bank;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rom_bank_switch u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr_hi(addr_hi), .data_lo(data_lo), .rom_bank(rom_bank));

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic cpu_write(input logic [2:0] a, input logic [4:0] d, input logic en = 1'b1);
    @(negedge clk);
    addr_hi = a; data_lo = d; wr_en = en;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic read_bank(input logic [2:0] a, output int v);
    @(negedge clk);
    addr_hi = a;
    #1 v = rom_bank;
  endtask

  task automatic t_reset;
    int v;
    read_bank(3'b010, v); check("R1", v, 1);
    read_bank(3'b011, v); check("R1", v, 1);
  endtask

  task automatic t_low_load;
    int v;
    cpu_write(3'b001, 5'h07); read_bank(3'b010, v); check("R2", v, 7);
    cpu_write(3'b001, 5'h1F); read_bank(3'b011, v); check("R2", v, 31);
  endtask

  task automatic t_zero;
    int v;
    cpu_write(3'b001, 5'h00); read_bank(3'b010, v); check("R3", v, 1);
    cpu_write(3'b001, 5'(8'd32)); read_bank(3'b010, v); check("R3", v, 1);
  endtask

  task automatic t_wrap;
    int v;
    cpu_write(3'b001, 5'd16); read_bank(3'b010, v);
    check("R4", v, 16); check("R4", v & 32'hF, 0);
    cpu_write(3'b001, 5'd8); read_bank(3'b010, v);
    check("R4", v, 8); check("R4", v & 32'h7, 0);
  endtask

  task automatic t_upper;
    int v;
    cpu_write(3'b001, 5'd5);
    cpu_write(3'b010, 5'b11110); read_bank(3'b010, v); check("R5", v, 32'h45);
  endtask

  task automatic t_upper_zero;
    int v;
    cpu_write(3'b010, 5'd3);
    cpu_write(3'b001, 5'd0); read_bank(3'b011, v); check("R9", v, 32'h61);
  endtask

  task automatic t_fixed;
    int v;
    read_bank(3'b000, v); check("R6", v, 0);
    read_bank(3'b001, v); check("R6", v, 0);
  endtask

  task automatic t_ignore;
    int v;
    cpu_write(3'b000, 5'h0A);
    cpu_write(3'b011, 5'h0B);
    cpu_write(3'b100, 5'h0C);
    cpu_write(3'b111, 5'h0D);
    read_bank(3'b010, v); check("R7", v, 32'h61);
  endtask

  task automatic t_no_strobe;
    int v;
    cpu_write(3'b001, 5'h09, 1'b0);
    cpu_write(3'b010, 5'h01, 1'b0);
    read_bank(3'b010, v); check("R8", v, 32'h61);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_fixed;
    t_low_load;
    t_zero;
    t_wrap;
    t_upper;
    t_upper_zero;
    t_ignore;
    t_no_strobe;
    done = 1;
    finish_run;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run;
    end
  end
endmodule